// File: doc/BRIEF.md
# Core-Local Machine Timer with Compare

This block is a timer that sits next to a processor core and asks the trap logic for a timer interrupt. It holds a free-running counter of two machine words, a low word and a high word, and a match value of the same width, also stored as two words. The counter advances once for every cycle in which the tick input is high. The carry from the low word moves into the high word. The interrupt request is a level. It is computed from the live counter and the live match value.

Software reaches the block through a simple word-wide register port. The address is decoded relative to a base address. The two match words can be read and written. The two counter words can only be read. Every other address reads as zero and ignores writes. Reads are combinational from the address. A write takes effect at the clock edge on which `wr_en_i` is high.

The compare rule differs from a plain "greater or equal". It fires when the high count word is strictly above the high match word. It also fires when both words are exactly equal. When the high words are equal but the low count word has already passed the low match word, the rule does not fire. A match value of all zeros disarms the compare.

Top module: `core_timer`

## Requirements
- R1: When `rst` is high at a clock edge, the counter and both match words become zero, and `irq_o` is low afterwards.
- R2: On each clock edge with `tick_i` high, the two-word counter grows by exactly one. With `tick_i` low, it keeps its value.
- R3: When the low counter word steps from all ones to zero, the high word grows by one in the same edge. The full counter wraps from all ones to zero.
- R4: A write at base+0x4000 loads the low match word, and a write at base+0x4004 loads the high match word. The new value is visible from the next clock edge.
- R5: While the match value is nonzero, `irq_o` is high whenever the high count word is greater than the high match word, or whenever both words are equal. It is evaluated on the register values after the latest edge, so it follows the counter after its increment, and it stays high for as long as the condition holds.
- R6: While both match words are zero, `irq_o` stays low for every counter value.
- R7: `rdata_o` returns the low match word at base+0x4000, the high match word at base+0x4004, the low counter word at base+0xBFF8 and the high counter word at base+0xBFFC.
- R8: `rdata_o` is zero for every other address, including unaligned offsets and addresses outside the 64 KiB window above the base.
- R9: Writes to the counter offsets or to any other address leave the counter and the match words unchanged.
- R10: If the high count word equals the high match word and the low words differ, `irq_o` is low, even when the low count word is above the low match word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Counter advance enable, one step per cycle |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | WORD_W | Write data |
| rdata_o | output | WORD_W | Combinational read data for `addr_i` |
| irq_o | output | 1 | Timer interrupt request level |

## Verification
A faulty counter or carry shows up on the counter read ports in the cycle after the bad edge. It also moves the interrupt edge by at least one tick. A corrupt match word is seen at once through its read offset, and in `irq_o` when the counter next crosses it. The bench uses an 8-bit word. This lets the counter wrap through all 65536 states, and the interrupt rule is checked against an arithmetic model at every cycle. That check covers the equal-high and low-passed corner and the zero-match disarm.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    // Offsets inside the 64 KiB decode window above the base address
    localparam int OFF_W = 16;
    localparam int NUM_WORDS = 2;

    localparam logic [OFF_W-1:0] OFF_MATCH_LO = 16'h4000;
    localparam logic [OFF_W-1:0] OFF_MATCH_HI = 16'h4004;
    localparam logic [OFF_W-1:0] OFF_COUNT_LO = 16'hBFF8;
    localparam logic [OFF_W-1:0] OFF_COUNT_HI = 16'hBFFC;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_MATCH_LO,
        RSEL_MATCH_HI,
        RSEL_COUNT_LO,
        RSEL_COUNT_HI
    } rsel_e;

    function automatic rsel_e decode_off(input logic [OFF_W-1:0] off);
        rsel_e r;
        case (off)
            OFF_MATCH_LO: r = RSEL_MATCH_LO;
            OFF_MATCH_HI: r = RSEL_MATCH_HI;
            OFF_COUNT_LO: r = RSEL_COUNT_LO;
            OFF_COUNT_HI: r = RSEL_COUNT_HI;
            default:      r = RSEL_NONE;
        endcase
        return r;
    endfunction

    // Register select that owns match word number w (0 = low)
    function automatic rsel_e match_sel_of(input int w);
        return (w == 0) ? RSEL_MATCH_LO : RSEL_MATCH_HI;
    endfunction

    function automatic logic sel_is_match(input rsel_e s);
        return (s == RSEL_MATCH_LO) || (s == RSEL_MATCH_HI);
    endfunction

endpackage

// File: rtl/ctm_decode.sv
module ctm_decode
    import ctm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0200_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output rsel_e             sel
);
    logic [ADDR_W-1:0] delta;
    logic              in_window;

    always_comb begin
        delta     = addr - BASE_ADDR;
        in_window = (delta[ADDR_W-1:OFF_W] == '0);
        sel       = in_window ? decode_off(delta[OFF_W-1:0]) : RSEL_NONE;
    end
endmodule

// File: rtl/ctm_counter.sv
module ctm_counter
    import ctm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    output logic [NUM_WORDS*WORD_W-1:0] count
);
    // carry[w] enables word w; word 0 is enabled by the tick itself
    logic [NUM_WORDS-1:0] carry;
    assign carry[0] = tick;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (carry[w]) begin
                word_q <= word_q + 1'b1;
            end
        end

        if (w < NUM_WORDS - 1) begin : g_ripple
            assign carry[w+1] = carry[w] & (&word_q);
        end

        assign count[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/ctm_match_regs.sv
module ctm_match_regs
    import ctm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  rsel_e                       sel,
    input  logic [WORD_W-1:0]           wdata,
    output logic [NUM_WORDS*WORD_W-1:0] match
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam rsel_e MY_SEL = match_sel_of(w);
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en && (sel == MY_SEL)) begin
                word_q <= wdata;
            end
        end

        assign match[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/ctm_compare.sv
module ctm_compare
    import ctm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [NUM_WORDS*WORD_W-1:0] count,
    input  logic [NUM_WORDS*WORD_W-1:0] match,
    output logic                        irq
);
    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } pair_t;

    pair_t c, m;
    logic  armed, hi_above, all_equal;

    always_comb begin
        c         = pair_t'(count);
        m         = pair_t'(match);
        armed     = |match;
        hi_above  = c.hi > m.hi;
        all_equal = (c.hi == m.hi) && (c.lo == m.lo);
        irq       = armed && (hi_above || all_equal);
    end
endmodule

// File: rtl/core_timer.sv
module core_timer
    import ctm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0200_0000,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int FULL_W = NUM_WORDS * WORD_W;

    rsel_e             rd_sel;
    logic [FULL_W-1:0] count_q;
    logic [FULL_W-1:0] match_q;

    ctm_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr (addr_i),
        .sel  (rd_sel)
    );

    ctm_counter #(.WORD_W(WORD_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_i),
        .count (count_q)
    );

    ctm_match_regs #(.WORD_W(WORD_W)) u_match (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en_i),
        .sel   (rd_sel),
        .wdata (wdata_i),
        .match (match_q)
    );

    ctm_compare #(.WORD_W(WORD_W)) u_compare (
        .count (count_q),
        .match (match_q),
        .irq   (irq_o)
    );

    always_comb begin
        case (rd_sel)
            RSEL_MATCH_LO: rdata_o = match_q[0      +: WORD_W];
            RSEL_MATCH_HI: rdata_o = match_q[WORD_W +: WORD_W];
            RSEL_COUNT_LO: rdata_o = count_q[0      +: WORD_W];
            RSEL_COUNT_HI: rdata_o = count_q[WORD_W +: WORD_W];
            default:       rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker
    import ctm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        tick,
    input logic                        wr_en,
    input rsel_e                       sel,
    input logic [NUM_WORDS*WORD_W-1:0] count,
    input logic [NUM_WORDS*WORD_W-1:0] match,
    input logic                        irq,
    input logic [WORD_W-1:0]           rdata
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count == '0) && (match == '0) && !irq);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == $past(count) + 1'b1);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R3
    low_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (&count[WORD_W-1:0])) |=>
            (count[WORD_W-1:0] == '0) &&
            (count[2*WORD_W-1:WORD_W] == $past(count[2*WORD_W-1:WORD_W]) + 1'b1));

    // R5
    fire_above_chk: assert property (@(posedge clk) disable iff (rst)
        ((match != '0) && (count[2*WORD_W-1:WORD_W] > match[2*WORD_W-1:WORD_W])) |-> irq);

    // R6
    zero_match_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (match == '0) |-> !irq);

    // R8
    other_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == RSEL_NONE) |-> (rdata == '0));

    // R9
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel_is_match(sel)) |=> $stable(match));
endmodule

bind core_timer ctm_checker #(.WORD_W(WORD_W)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_i),
    .wr_en (wr_en_i),
    .sel   (rd_sel),
    .count (count_q),
    .match (match_q),
    .irq   (irq_o),
    .rdata (rdata_o)
);

// File: tb/core_timer_tb_top.sv
module core_timer_tb_top;
    localparam int ADDR_W = 32;
    localparam logic [31:0] BASE = 32'h0200_0000;
    localparam int WORD_W = 8;

    localparam logic [31:0] A_MLO = BASE + 32'h4000;
    localparam logic [31:0] A_MHI = BASE + 32'h4004;
    localparam logic [31:0] A_CLO = BASE + 32'hBFF8;
    localparam logic [31:0] A_CHI = BASE + 32'hBFFC;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = A_CLO;
    logic              wr_en_i = 1'b0;
    logic [WORD_W-1:0] wdata_i = '0;
    logic [WORD_W-1:0] rdata_o;
    logic              irq_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    core_timer #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .WORD_W(WORD_W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // Arithmetic reference state
    logic [2*WORD_W-1:0] m_cnt;
    logic [WORD_W-1:0]   m_ml, m_mh;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0;
            m_ml  <= '0;
            m_mh  <= '0;
        end else begin
            if (tick_i) m_cnt <= m_cnt + 1'b1;
            if (wr_en_i && addr_i == A_MLO) m_ml <= wdata_i;
            if (wr_en_i && addr_i == A_MHI) m_mh <= wdata_i;
        end
    end

    function automatic logic exp_irq();
        logic [WORD_W-1:0] ch, cl;
        ch = m_cnt[2*WORD_W-1:WORD_W];
        cl = m_cnt[WORD_W-1:0];
        if (m_ml == '0 && m_mh == '0) return 1'b0;
        return (ch > m_mh) || (ch == m_mh && cl == m_ml);
    endfunction

    function automatic logic [WORD_W-1:0] exp_rd(input logic [31:0] a);
        if (a == A_MLO) return m_ml;
        if (a == A_MHI) return m_mh;
        if (a == A_CLO) return m_cnt[WORD_W-1:0];
        if (a == A_CHI) return m_cnt[2*WORD_W-1:WORD_W];
        return '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison of both outputs, 3 ns after each edge
    always @(posedge clk) begin
        #3;
        if (!rst && !done) begin
            if (m_ml == '0 && m_mh == '0)
                check("R6 irq disarmed", {31'd0, irq_o}, 32'd0);
            else if (m_cnt[2*WORD_W-1:WORD_W] == m_mh && m_cnt[WORD_W-1:0] != m_ml)
                check("R10 equal high, low differs", {31'd0, irq_o}, 32'd0);
            else
                check("R5 irq rule", {31'd0, irq_o}, {31'd0, exp_irq()});
            if (addr_i == A_MLO || addr_i == A_MHI || addr_i == A_CLO || addr_i == A_CHI)
                check("R7 register read", {24'd0, rdata_o}, {24'd0, exp_rd(addr_i)});
            else
                check("R8 unmapped read", {24'd0, rdata_o}, 32'd0);
        end
    end

    task automatic cyc(input logic t, input logic [31:0] a, input logic we, input logic [WORD_W-1:0] d);
        @(negedge clk);
        tick_i  = t;
        addr_i  = a;
        wr_en_i = we;
        wdata_i = d;
    endtask

    task automatic peek(input logic [31:0] a, input logic [WORD_W-1:0] e, input string req);
        @(negedge clk);
        tick_i  = 1'b0;
        wr_en_i = 1'b0;
        addr_i  = a;
        #1;
        check(req, {24'd0, rdata_o}, {24'd0, e});
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [15:0] snap;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        peek(A_CLO, 8'h00, "R1 count lo after reset");
        peek(A_CHI, 8'h00, "R1 count hi after reset");
        peek(A_MLO, 8'h00, "R1 match lo after reset");
        peek(A_MHI, 8'h00, "R1 match hi after reset");
        check("R1 irq after reset", {31'd0, irq_o}, 32'd0);

        // R2/R3: 300 ticks with the compare disarmed, crossing the low wrap
        for (int i = 0; i < 300; i++) cyc(1'b1, A_CLO, 1'b0, '0);
        peek(A_CHI, 8'h01, "R3 carry into high word");
        peek(A_CLO, 8'd44, "R2 low word after 300 ticks");
        repeat (10) cyc(1'b0, A_CLO, 1'b0, '0);
        peek(A_CLO, 8'd44, "R2 hold with tick low");

        // R4: match load and readback
        cyc(1'b0, A_MLO, 1'b1, 8'h10);
        cyc(1'b0, A_MHI, 1'b1, 8'h03);
        peek(A_MLO, 8'h10, "R4 match lo readback");
        peek(A_MHI, 8'h03, "R4 match hi readback");

        // R9: writes to counter and unmapped offsets are ignored
        cyc(1'b0, A_CLO, 1'b1, 8'hAA);
        cyc(1'b0, A_CHI, 1'b1, 8'h55);
        cyc(1'b0, BASE + 32'h4002, 1'b1, 8'h77);
        cyc(1'b0, BASE + 32'h1_4000, 1'b1, 8'h66);
        peek(A_CLO, 8'd44, "R9 count lo untouched");
        peek(A_CHI, 8'h01, "R9 count hi untouched");
        peek(A_MLO, 8'h10, "R9 match lo untouched");
        peek(A_MHI, 8'h03, "R9 match hi untouched");
        peek(BASE + 32'h1_4000, 8'h00, "R8 outside window reads zero");

        // R5/R10: run through 0x0310 and beyond the high match
        for (int i = 0; i < 1200; i++) cyc(1'b1, A_CHI, 1'b0, '0);

        // Full wrap of the 16-bit counter with the compare armed
        for (int i = 0; i < 66000; i++) cyc(1'b1, (i % 2 == 0) ? A_CLO : A_CHI, 1'b0, '0);
        snap = 16'((300 + 1200 + 66000) % 65536);
        peek(A_CLO, snap[7:0], "R3 full wrap low");
        peek(A_CHI, snap[15:8], "R3 full wrap high");

        // Pseudo-random mixed traffic
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0: a = A_MLO;
                3'd1: a = A_MHI;
                3'd2: a = A_CLO;
                3'd3: a = A_CHI;
                3'd4: a = BASE + 32'hBFFA;
                3'd5: a = BASE - 32'h4;
                default: a = A_CHI;
            endcase
            cyc(lfsr[3] | lfsr[4], a, (lfsr[7:5] == 3'd0), lfsr[15:8]);
        end

        // R1: mid-run reset clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        peek(A_MHI, 8'h00, "R1 match hi after second reset");
        peek(A_CHI, 8'h00, "R1 count hi after second reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule